// File: doc/BRIEF.md
# Deferred Line Write-Back Buffer

This block sits beside a data cache and holds one dirty victim line that is being evicted. When the cache picks a dirty line for replacement, it hands over the whole line in one cycle, together with the line address and the word offset of the access that missed. The cache can then start its refill burst at once. The buffer keeps the victim and does not touch the memory bus. When the cache controller signals that the refill has finished, the buffer drains the line to external memory as a four-word write burst.

The burst uses the same wrap-around word order as the refill. It starts at the word that missed, climbs through the higher words and wraps back to word zero. Each write word is held on the memory port until memory acknowledges it. While the buffer holds undrained data it reports busy and refuses a new victim, so the cache has to stall its next eviction.

Top module: `wb_line_buffer`

## Requirements
- R1: On a cycle where `evict_ready` is 1 and `evict_valid` is 1, the buffer captures all four words of `evict_data` and `evict_line`. Word k is `evict_data[32k+31:32k]`. Every write issued later carries the captured data, whatever values the inputs take afterwards.
- R2: The write burst issues exactly four writes. Their word offsets are s, s+1, s+2, s+3 modulo 4, where s is the `evict_ofs` value captured. Each `mem_addr` is {captured line, word offset (bits 3:2), 2'b00}, and `mem_data` is the word at that offset. For s = 1 the byte offsets are 0x4, 0x8, 0xC, 0x0.
- R3: No write is presented until a `refill_done` pulse arrives in a cycle after the capture cycle. A `refill_done` in the capture cycle or while idle has no effect. The first write appears in the cycle after that pulse.
- R4: While `busy` is 1, `evict_ready` is 0 and `evict_valid` is ignored. The line being drained is not altered.
- R5: While `mem_valid` is 1 and `mem_ack` is 0, the address and data hold steady. A `mem_ack` while `mem_valid` is 0 has no effect. The next write appears in the cycle after an acknowledged one.
- R6: In the cycle after the fourth acknowledgement, `mem_valid` and `busy` drop and `evict_ready` returns to 1.
- R7: After synchronous reset `busy` is 0, `evict_ready` is 1 and `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Cache offers a dirty victim line |
| evict_ready | output | 1 | Buffer can accept a victim (not busy) |
| evict_line | input | 28 | Victim line address (tag and index) |
| evict_data | input | 128 | Victim line, word k at bits 32k+31:32k |
| evict_ofs | input | 2 | Word offset of the missing access |
| refill_done | input | 1 | One-cycle pulse: cache refill burst finished |
| busy | output | 1 | Buffer holds data not yet written back |
| mem_valid | output | 1 | Write word presented to memory |
| mem_addr | output | 32 | Byte address of the write word |
| mem_data | output | 32 | Write word |
| mem_ack | input | 1 | Memory accepted the presented word |

## Verification
The assertions assume that memory raises `mem_ack` only in answer to a presented word, and that `refill_done` is a pulse that may arrive at any time, including stray pulses while idle. The stimulus drives acknowledgements from a background process in three modes: always, never and random. It uses stray acks and refill pulses and offers evictions while busy. Every input changes on the falling edge. An independent queue-based model is compared with the outputs on every falling edge.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_HOLD  = 2'd1,
    WB_DRAIN = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wbb_line_store.sv
module wbb_line_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINE_W = 28,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [WORDS*DATA_W-1:0] line_in,
  input  logic [LINE_W-1:0]       tag_in,
  input  logic [OFS_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_word,
  output logic [LINE_W-1:0]       tag_q
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en) mem[g] <= line_in[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q <= tag_in;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evict_valid,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             refill_done,
  input  logic             ack,
  output logic             busy,
  output logic             capture,
  output logic             load,
  output logic [OFS_W-1:0] idx,
  output logic             done
);
  wb_state_e        state;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] cnt;

  assign busy    = (state != WB_IDLE);
  assign capture = (state == WB_IDLE) && evict_valid;

  always_comb begin
    load = 1'b0;
    done = 1'b0;
    idx  = ofs;
    if (state == WB_HOLD && refill_done) begin
      load = 1'b1;
    end else if (state == WB_DRAIN && ack) begin
      if (cnt == OFS_W'(WORDS - 1)) begin
        done = 1'b1;
      end else begin
        load = 1'b1;
        idx  = ofs + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WB_IDLE;
      ofs   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        WB_IDLE: if (capture) begin
          state <= WB_HOLD;
          ofs   <= start_ofs;
          cnt   <= '0;
        end
        WB_HOLD: if (refill_done) state <= WB_DRAIN;
        WB_DRAIN: if (ack) begin
          if (done) begin
            state <= WB_IDLE;
          end else begin
            ofs <= ofs + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= WB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_line_buffer.sv
module wb_line_buffer #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 32,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int LINE_W = ADDR_W - OFS_W - BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    evict_valid,
  output logic                    evict_ready,
  input  logic [LINE_W-1:0]       evict_line,
  input  logic [WORDS*DATA_W-1:0] evict_data,
  input  logic [OFS_W-1:0]        evict_ofs,
  input  logic                    refill_done,
  output logic                    busy,
  output logic                    mem_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_data,
  input  logic                    mem_ack
);
  logic              capture, load, done;
  logic [OFS_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic [LINE_W-1:0] tag_q;

  wbb_seq #(.WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .evict_valid(evict_valid),
    .start_ofs  (evict_ofs),
    .refill_done(refill_done),
    .ack        (mem_ack),
    .busy       (busy),
    .capture    (capture),
    .load       (load),
    .idx        (idx),
    .done       (done)
  );

  wbb_line_store #(.DATA_W(DATA_W), .WORDS(WORDS), .LINE_W(LINE_W)) u_store (
    .clk    (clk),
    .wr_en  (capture),
    .line_in(evict_data),
    .tag_in (evict_line),
    .rd_idx (idx),
    .rd_word(rd_word),
    .tag_q  (tag_q)
  );

  assign evict_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= {tag_q, idx, {BYTE_W{1'b0}}};
      mem_data  <= rd_word;
    end else if (done) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wb_line_buffer_chk.sv
module wb_line_buffer_chk #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 32,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int HI     = BYTE_W + OFS_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              evict_ready,
  input logic              refill_done,
  input logic              busy,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ack
);
  assert_first_after_refill_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_valid) |-> $past(refill_done));

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_wrap_order_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ack |=> !mem_valid ||
      (mem_addr[HI:BYTE_W] == OFS_W'($past(mem_addr[HI:BYTE_W]) + 1'b1) &&
       mem_addr[ADDR_W-1:HI+1] == $past(mem_addr[ADDR_W-1:HI+1])));

  assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy && !evict_ready);

  assert_release_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_valid && mem_ack));

  assert_reset_idle_R7: assert property (@(posedge clk)
    $past(rst) |-> !busy && !mem_valid);
endmodule

bind wb_line_buffer wb_line_buffer_chk #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evict_ready(evict_ready),
  .refill_done(refill_done),
  .busy       (busy),
  .mem_valid  (mem_valid),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .mem_ack    (mem_ack)
);

// File: tb/tb_wb_line_buffer.sv
module tb_wb_line_buffer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         evict_valid = 1'b0;
  logic         evict_ready;
  logic [27:0]  evict_line = '0;
  logic [127:0] evict_data = '0;
  logic [1:0]   evict_ofs = '0;
  logic         refill_done = 1'b0;
  logic         busy;
  logic         mem_valid;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_data;
  logic         mem_ack = 1'b0;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int ack_mode = 0;   // 0 always, 1 never, 2 random

  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  bit          armed = 0;

  wb_line_buffer dut (.*);

  always #2 clk = ~clk;

  // reference model: queue of pending writes
  always @(posedge clk) begin
    if (rst) begin
      q_addr.delete(); q_data.delete(); armed = 0;
    end else if (q_addr.size() == 0 && evict_valid) begin
      for (int k = 0; k < 4; k++) begin
        int o;
        o = (int'(evict_ofs) + k) % 4;
        q_addr.push_back({evict_line, 2'(o), 2'b00});
        q_data.push_back(evict_data[32*o +: 32]);
      end
      armed = 0;
    end else if (q_addr.size() != 0 && !armed && refill_done) begin
      armed = 1;
    end else if (armed && q_addr.size() != 0 && mem_ack) begin
      void'(q_addr.pop_front()); void'(q_data.pop_front());
      if (q_addr.size() == 0) armed = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    bit ev, eb;
    cycles++;
    ev = armed && q_addr.size() != 0;
    eb = q_addr.size() != 0;
    vectors++;
    if (mem_valid !== ev) begin
      errors++; $display("FAIL R3 R5 R6 R7 mem_valid act=%0b exp=%0b t=%0t", mem_valid, ev, $time);
    end
    if (busy !== eb) begin
      errors++; $display("FAIL R6 R7 busy act=%0b exp=%0b t=%0t", busy, eb, $time);
    end
    if (evict_ready !== !eb) begin
      errors++; $display("FAIL R4 evict_ready act=%0b exp=%0b t=%0t", evict_ready, !eb, $time);
    end
    if (ev && mem_valid === 1'b1) begin
      if (mem_addr !== q_addr[0]) begin
        errors++; $display("FAIL R2 mem_addr act=%h exp=%h t=%0t", mem_addr, q_addr[0], $time);
      end
      if (mem_data !== q_data[0]) begin
        errors++; $display("FAIL R1 mem_data act=%h exp=%h t=%0t", mem_data, q_data[0], $time);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // background acknowledgement driver
  always @(negedge clk) begin
    case (ack_mode)
      0: mem_ack <= 1'b1;
      1: mem_ack <= 1'b0;
      default: mem_ack <= 1'($urandom % 2);
    endcase
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer(logic [27:0] ln, logic [1:0] o, bit with_refill);
    evict_line  = ln;
    evict_ofs   = o;
    evict_data  = {$urandom, $urandom, $urandom, $urandom};
    evict_valid = 1'b1;
    refill_done = with_refill;
    step(1);
    evict_valid = 1'b0;
    refill_done = 1'b0;
  endtask

  task automatic pulse_refill();
    refill_done = 1'b1;
    step(1);
    refill_done = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) step(1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;                       // R7 reset state compared above
    // stray refill and ack while idle: ignored (R3, R5)
    pulse_refill();
    step(2);
    // R2 start at offset 0, back-to-back acks
    offer(28'h0123456, 2'd0, 1'b0);
    step(2);
    pulse_refill();
    wait_idle();
    // R3 refill in capture cycle ignored; R2 offset 1 gives 0x4,0x8,0xC,0x0
    ack_mode = 1;
    offer(28'h0ABCDEF, 2'd1, 1'b1);
    step(4);
    // R4 eviction offered while busy must not disturb the held line
    offer(28'h0FFFFFF, 2'd2, 1'b0);
    step(2);
    pulse_refill();
    step(5);                          // R5 words held without ack
    ack_mode = 2;
    wait_idle();
    // R6 release then immediate re-capture, offset 3
    ack_mode = 0;
    offer(28'h0000001, 2'd3, 1'b0);
    pulse_refill();
    wait_idle();
    // random mix of offsets, gaps and ack patterns
    ack_mode = 2;
    for (int i = 0; i < 40; i++) begin
      offer(28'($urandom), 2'($urandom), 1'($urandom % 2));
      step(int'($urandom % 4));
      if (i % 3 == 0) offer(28'($urandom), 2'($urandom), 1'b0);   // R4
      pulse_refill();
      if (i % 5 == 0) pulse_refill();                              // R3 extra pulse
      wait_idle();
      step(int'($urandom % 3));
    end
    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule